// File: doc/BRIEF.md
# Phase Modulation Word Control

This block decides where the 12-bit phase-modulation word for an oscillator's phase adder comes from, and when a new value takes hold. A level input picks one of two sources. In the direct source, the 4-bit address lines and the 8-bit data lines together carry the whole word, which is captured when the phase-load input falls. In the buffered source, software first fills a 12-bit staging register with two byte writes through the ordinary bus write strobe. The next falling edge of phase-load then copies the staged value into the output word.

The write strobe and the phase-load input are taken as asynchronous. Each is brought into the clock domain through a synchronizer and turned into a one-cycle pulse on the edge that matters. A phase-sync output gives a single-cycle pulse a fixed number of clocks after every commit, so that the pulse lines up with the moment the new phase shows up at the end of the downstream pipeline. Commits may follow each other as closely as once every four clocks, and each one gets its own sync pulse.

Top module: `pm_word_ctrl`

## Requirements
- R1: While the synchronous active-low reset is applied, `pm_word` is 0 and `pm_sync` is 0. The staging register also clears to 0: a buffered commit made after reset, with no writes in between, yields 0.
- R2: When `src_buf` is 0 at a commit, `pm_word` becomes {`bus_addr`[3:0], `bus_data`[7:0]`}, with the address lines in bits 11:8.
- R3: A rising edge of `wr_stb` while `src_buf` is 1 writes the staging register. Address 4'h4 loads bits 7:0 from `bus_data`. Address 4'h5 loads bits 11:8 from `bus_data`[3:0].
- R4: A write strobe leaves the staging register unchanged when `src_buf` is 0, or when the address is neither 4'h4 nor 4'h5.
- R5: When `src_buf` is 1 at a commit, `pm_word` becomes the staging register contents, and the bus lines have no effect.
- R6: `pm_word` changes only on the third rising clock edge after `pld_n` falls. It holds its value at every other edge, and a rising `pld_n` does not change it.
- R7: `pm_sync` is high for exactly one cycle, starting at the fourteenth rising edge after `pld_n` falls. This is 12 clocks after the commit cycle.
- R8: Falling edges of `pld_n` spaced four clocks apart each commit their own word, and each produces its own `pm_sync` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_buf | input | 1 | Source select: 0 = direct bus word, 1 = staging register |
| bus_addr | input | 4 | Bus address; upper nibble of the word in direct mode |
| bus_data | input | 8 | Bus data; low byte of the word in direct mode |
| wr_stb | input | 1 | Asynchronous bus write strobe, acts on its rising edge |
| pld_n | input | 1 | Asynchronous phase-load strobe, commits on its falling edge |
| pm_word | output | 12 | Committed phase-modulation word |
| pm_sync | output | 1 | One-cycle pulse marking when the commit reaches the output |

## Verification
The table walk commits words from both sources. In the direct entries, the address nibble and the data byte are set to unrelated values, so a swapped or shifted field shows up. In the buffered entries, the bus carries a decoy word during the commit, which separates a correct source choice from a wrong one. The directed tests cover three further cases. A write made in direct mode, or to an unrelated address, must not disturb the staged word. Two commits four clocks apart must both land, with two separate sync pulses. The checks one cycle early and one cycle late around each update and each sync pulse catch any change to the pipeline depth.

// File: rtl/pm_pkg.sv
// Package: shared widths and types for the phase-modulation word control.
// Assumes the upper field of the word is no wider than one data byte.
package pm_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int WORD_W    = DATA_W + ADDR_W;
    localparam int SYNC_LAT  = 12;
    localparam int META_STG  = 2;

    typedef enum logic {
        SRC_DIRECT = 1'b0,
        SRC_STAGED = 1'b1
    } pm_src_e;
endpackage

// File: rtl/pm_edge_sync.sv
// Module: brings an asynchronous strobe into the clock domain and emits a
// one-cycle pulse on the chosen edge. Assumes the strobe holds each level
// for at least two clocks. IDLE is the reset level of the chain.
module pm_edge_sync #(
    parameter int   STAGES  = 2,
    parameter bit   ON_RISE = 1'b1,
    parameter logic IDLE    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic pulse
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Purpose: shift the raw input through the meta stages plus a history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {CHAIN_W{IDLE}};
        else        chain_q <= {chain_q[CHAIN_W-2:0], async_in};
    end

    generate
        if (ON_RISE) begin : g_rise
            // Purpose: flag a low-to-high step at the synchronized output.
            always_comb pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
        end else begin : g_fall
            // Purpose: flag a high-to-low step at the synchronized output.
            always_comb pulse = ~chain_q[STAGES-1] & chain_q[STAGES];
        end
    endgenerate
endmodule

// File: rtl/pm_stage_reg.sv
// Module: staging register for the buffered source. It takes the low byte
// at LO_ADDR and the upper field at LO_ADDR+1, only when enabled.
// Assumes wr_p is a single-cycle pulse with the bus lines already stable.
module pm_stage_reg #(
    parameter int              DATA_W  = 8,
    parameter int              ADDR_W  = 4,
    parameter int              WORD_W  = 12,
    parameter logic [ADDR_W-1:0] LO_ADDR = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_p,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [WORD_W-1:0] stage_q
);
    localparam int                HI_W    = WORD_W - DATA_W;
    localparam logic [ADDR_W-1:0] HI_ADDR = LO_ADDR + 1'b1;

    logic hit_lo;
    logic hit_hi;

    // Purpose: decode which half of the staging word a write addresses.
    always_comb begin
        hit_lo = wr_p && en && (addr == LO_ADDR);
        hit_hi = wr_p && en && (addr == HI_ADDR);
    end

    // Purpose: hold the low byte of the staged word.
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q[DATA_W-1:0] <= '0;
        else if (hit_lo) stage_q[DATA_W-1:0] <= data;
    end

    // Purpose: hold the upper field of the staged word.
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q[WORD_W-1:DATA_W] <= '0;
        else if (hit_hi) stage_q[WORD_W-1:DATA_W] <= data[HI_W-1:0];
    end
endmodule

// File: rtl/pm_sync_delay.sv
// Module: delays each commit pulse by LAT clocks to mark when the change
// reaches the waveform output. Overlapping commits each travel on their own.
module pm_sync_delay #(
    parameter int LAT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_p,
    output logic out_p
);
    logic [LAT-1:0] line_q;

    generate
        if (LAT == 1) begin : g_one
            // Purpose: single-stage delay.
            always_ff @(posedge clk) begin
                if (!rst_n) line_q <= '0;
                else        line_q <= in_p;
            end
        end else begin : g_many
            // Purpose: shift the commit pulse down the delay line.
            always_ff @(posedge clk) begin
                if (!rst_n) line_q <= '0;
                else        line_q <= {line_q[LAT-2:0], in_p};
            end
        end
    endgenerate

    assign out_p = line_q[LAT-1];
endmodule

// File: rtl/pm_word_ctrl.sv
// Module: top of the phase-modulation word control. It picks the direct bus
// word or the staged word and commits it on a falling phase-load edge.
// Assumes src_buf and the bus lines are steady around a commit or a write.
module pm_word_ctrl
    import pm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAGE_ADDR = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_buf,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              wr_stb,
    input  logic              pld_n,
    output logic [WORD_W-1:0] pm_word,
    output logic              pm_sync
);
    logic              wr_p;
    logic              commit_p;
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] next_word;
    pm_src_e           src_sel;

    pm_edge_sync #(.STAGES(META_STG), .ON_RISE(1'b1), .IDLE(1'b0)) u_wr_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wr_stb),
        .pulse    (wr_p)
    );

    pm_edge_sync #(.STAGES(META_STG), .ON_RISE(1'b0), .IDLE(1'b1)) u_ld_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pld_n),
        .pulse    (commit_p)
    );

    pm_stage_reg #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .WORD_W  (WORD_W),
        .LO_ADDR (STAGE_ADDR)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_p    (wr_p),
        .en      (src_buf),
        .addr    (bus_addr),
        .data    (bus_data),
        .stage_q (stage_q)
    );

    // Purpose: choose the word that the next commit will load.
    always_comb begin
        src_sel = pm_src_e'(src_buf);
        case (src_sel)
            SRC_STAGED: next_word = stage_q;
            default:    next_word = {bus_addr, bus_data};
        endcase
    end

    // Purpose: commit register that feeds the phase adder.
    always_ff @(posedge clk) begin
        if (!rst_n)        pm_word <= '0;
        else if (commit_p) pm_word <= next_word;
    end

    pm_sync_delay #(.LAT(SYNC_LAT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_p  (commit_p),
        .out_p (pm_sync)
    );
endmodule

// File: rtl/pm_word_ctrl_chk.sv
// Checker: properties over the commit path of pm_word_ctrl, bound below.
module pm_word_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        src_buf,
    input logic [3:0]  bus_addr,
    input logic [7:0]  bus_data,
    input logic        wr_p,
    input logic        commit_p,
    input logic [11:0] stage_q,
    input logic [11:0] pm_word,
    input logic        pm_sync
);
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_p && !src_buf) |=> pm_word == $past({bus_addr, bus_data})); // R2

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_p && !src_buf) |=> $stable(stage_q)); // R4

    AST_STAGED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_p && src_buf) |=> pm_word == $past(stage_q)); // R5

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_p |=> $stable(pm_word)); // R6

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pm_sync |=> !pm_sync); // R7
endmodule

bind pm_word_ctrl pm_word_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_buf  (src_buf),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .wr_p     (wr_p),
    .commit_p (commit_p),
    .stage_q  (stage_q),
    .pm_word  (pm_word),
    .pm_sync  (pm_sync)
);

// File: tb/sim_pm_word_ctrl.sv
module sim_pm_word_ctrl;
    localparam int CLK_PER = 10;
    localparam int NVEC    = 6;
    // entry: {src_buf, hi nibble, low byte, expected word}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 4'h3, 8'h5A, 12'h35A},
        {1'b0, 4'hF, 8'hFF, 12'hFFF},
        {1'b1, 4'hA, 8'h3C, 12'hA3C},
        {1'b0, 4'h0, 8'h00, 12'h000},
        {1'b1, 4'h1, 8'h80, 12'h180},
        {1'b1, 4'hF, 8'h01, 12'hF01}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_buf = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        wr_stb = 1'b0;
    logic        pld_n = 1'b1;
    logic [11:0] pm_word;
    logic        pm_sync;

    int total = 0;
    int bad   = 0;
    int sync_cnt;
    logic [11:0] cur_word = '0;

    always #(CLK_PER/2) clk = ~clk;

    pm_word_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_buf(src_buf), .bus_addr(bus_addr),
        .bus_data(bus_data), .wr_stb(wr_stb), .pld_n(pld_n),
        .pm_word(pm_word), .pm_sync(pm_sync)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a;
        bus_data = d;
        wr_stb   = 1'b1;
        step(4);
        wr_stb   = 1'b0;
        step(3);
    endtask

    // Commit at this negedge and check the word and sync timing.
    task automatic commit_check(input logic [11:0] exp, input string req);
        pld_n = 1'b0;
        step(2);
        check("R6 early", pm_word, cur_word);
        step(1);
        check(req, pm_word, exp);
        cur_word = exp;
        step(10);
        check("R7 early", {11'd0, pm_sync}, 12'd0);
        step(1);
        check("R7 pulse", {11'd0, pm_sync}, 12'd1);
        pld_n = 1'b1;
        step(1);
        check("R7 single", {11'd0, pm_sync}, 12'd0);
        check("R6 rise", pm_word, exp);
        step(3);
    endtask

    initial begin
        step(3);
        check("R1 word", pm_word, 12'h000);
        check("R1 sync", {11'd0, pm_sync}, 12'd0);
        rst_n = 1'b1;
        step(2);

        // R1: staging register is clear after reset
        src_buf  = 1'b1;
        bus_addr = 4'h9;
        bus_data = 8'h77;
        cur_word = 12'h000;
        commit_check(12'h000, "R1 staged");

        // Table walk: R2 direct, R3 and R5 buffered
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][24]) begin
                src_buf = 1'b1;
                bus_write(4'h4, VEC[i][19:12]);
                bus_write(4'h5, {4'h0, VEC[i][23:20]});
                bus_addr = 4'h2;
                bus_data = 8'hC3;
                commit_check(VEC[i][11:0], "R3/R5 staged");
            end else begin
                src_buf  = 1'b0;
                bus_addr = VEC[i][23:20];
                bus_data = VEC[i][19:12];
                commit_check(VEC[i][11:0], "R2 direct");
            end
        end

        // R4: writes in direct mode and to other addresses are ignored
        src_buf = 1'b0;
        bus_write(4'h4, 8'h55);
        bus_write(4'h5, 8'h06);
        src_buf = 1'b1;
        bus_write(4'h3, 8'hEE);
        bus_write(4'h6, 8'h0E);
        bus_addr = 4'h1;
        bus_data = 8'h11;
        commit_check(12'hF01, "R4 ignored");

        // R8: commits four clocks apart
        src_buf  = 1'b0;
        bus_addr = 4'h7;
        bus_data = 8'h21;
        sync_cnt = 0;
        pld_n = 1'b0;
        step(2);
        pld_n = 1'b1;
        step(1);
        check("R8 first", pm_word, 12'h721);
        bus_addr = 4'hB;
        bus_data = 8'hD4;
        step(1);
        pld_n = 1'b0;
        step(3);
        check("R8 second", pm_word, 12'hBD4);
        pld_n = 1'b1;
        for (int c = 7; c < 20; c++) begin
            step(1);
            if (pm_sync) sync_cnt++;
            if (c + 1 == 14) check("R8 sync1", {11'd0, pm_sync}, 12'd1);
            if (c + 1 == 18) check("R8 sync2", {11'd0, pm_sync}, 12'd1);
        end
        check("R8 count", sync_cnt[11:0], 12'd2);
        cur_word = 12'hBD4;

        // R1: reset in operation clears the word
        rst_n = 1'b0;
        step(2);
        check("R1 rerun", pm_word, 12'h000);
        rst_n = 1'b1;
        step(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PER * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule